// File: doc/BRIEF.md
# SD Block-Gap Pause Controller

This block is the pause and resume logic of an SD/SDIO host data path. It sits between a control register written by software and a data engine that moves one block at a time. It holds four control bits: stop request, continue request, read-wait enable and gap-interrupt enable. It counts the blocks of a transfer and tells the data engine, through `blk_go`, whether it may run the next block.

When software asks for a stop, the transfer keeps going until the current block finishes. It then parks at the gap between blocks. A paused read keeps the card from sending more data in one of two ways. If read-wait is enabled, the block asks for read-wait signalling on DAT[2]. Otherwise it asks for the card clock to be stopped. A paused write needs neither request. Software resumes the transfer by writing the continue bit while leaving the stop bit clear. The continue bit then clears itself as the transfer becomes active again. The block also reports transfer status, a one-cycle pulse when the pause starts, and a one-cycle pulse when the transfer completes.

All outputs except `gap_irq_en` come from flip-flops that change on the clock edge where the state changes. `gap_irq_en` is the gap-interrupt bit ANDed with the 4-bit bus mode input.

Top module: `sd_gap_pause`

## Requirements
- R1: After a synchronous reset, `ctl_q` reads 0 and every status, request and pulse output is 0.
- R2: A write stores bit0 as the stop request, bit2 as the read-wait enable and bit3 as the gap-interrupt enable. `ctl_q` returns them in those positions, with the continue request at bit1.
- R3: A write sets the continue request only when bit1 of the written data is 1 and bit0 of the same data is 0. A write of 0 to bit1 never clears it.
- R4: `xfer_start` with a nonzero `xfer_blocks` in the idle state starts a transfer. While the transfer runs, `blk_go`, `dat_active` and `dat_inhibit` are 1. `rd_active` is 1 for reads (`xfer_is_read`=1) and `wr_active` is 1 for writes. A stop request takes effect only at a `blk_end` pulse.
- R5: `gap_evt` is 1 for exactly the one cycle after the clock edge on which a pause begins.
- R6: A paused transfer stays paused until the continue request is 1 while the stop request is 0. Clearing both bits does not resume it.
- R7: The continue request reads 0 from the same cycle in which `dat_active` (and the direction's active flag) rises from 0 to 1.
- R8: During a paused read, `rdwait_req` equals the read-wait enable and `clk_stop_req` equals its inverse. During a paused write, both are 0.
- R9: The `blk_end` that ends the last block produces a one-cycle `xfer_done` and clears the stop request. This happens even when a stop was requested, and no pause occurs.
- R10: `gap_irq_en` is 1 exactly when the gap-interrupt enable is 1 and `bus_4bit` is 1.
- R11: While paused, `blk_go`, `rd_active`, `wr_active`, `dat_active` and `dat_inhibit` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr_en | input | 1 | Control register write strobe |
| ctl_wr_data | input | 4 | Control write data (bit0 stop, bit1 continue, bit2 read-wait, bit3 gap interrupt) |
| ctl_q | output | 4 | Control register readback |
| bus_4bit | input | 1 | Bus is in 4-bit mode |
| xfer_start | input | 1 | Start a transfer (only in idle) |
| xfer_is_read | input | 1 | Direction of the started transfer: 1 read, 0 write |
| xfer_blocks | input | CNT_W | Block count of the started transfer |
| blk_end | input | 1 | Data engine finished a block |
| blk_go | output | 1 | Data engine may run blocks |
| rd_active | output | 1 | Read transfer active |
| wr_active | output | 1 | Write transfer active |
| dat_active | output | 1 | DAT line active |
| dat_inhibit | output | 1 | Data commands inhibited |
| rdwait_req | output | 1 | Request read-wait signalling on DAT[2] |
| clk_stop_req | output | 1 | Request card clock stop |
| xfer_done | output | 1 | One-cycle transfer-complete pulse |
| gap_evt | output | 1 | One-cycle pause-begins pulse |
| gap_irq_en | output | 1 | Interrupt detection at the gap is enabled |

## Verification
The bench runs four kinds of transfer:
- A write that runs to completion without a stop shows that block counting and the done pulse work without any pause.
- A read with read-wait enabled is stopped mid-block. It then receives a clear-both write and a stop-plus-continue write. These show that the stop waits for the block boundary, and they separate a true resume from the two writes that must not resume.
- A read with read-wait disabled shows the clock-stop request in place of read-wait. A paused write shows that neither hold request is raised.
- A single-block write with a stop already pending shows that the last boundary completes the transfer instead of pausing.

// File: rtl/sd_gap_pkg.sv
package sd_gap_pkg;
  localparam int CTL_W      = 4;
  localparam int CTL_STOP   = 0;
  localparam int CTL_CONT   = 1;
  localparam int CTL_RDWAIT = 2;
  localparam int CTL_GAPIE  = 3;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_PAUSE = 2'd2,
    ST_DONE  = 2'd3
  } gap_state_e;
endpackage

// File: rtl/gap_ctl_regs.sv
module gap_ctl_regs
  import sd_gap_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [CTL_W-1:0] wr_data,
  input  logic             restart,
  input  logic             done_clr,
  output logic             stop_q,
  output logic             cont_q,
  output logic             rdwait_q,
  output logic             gapie_q,
  output logic             rdwait_nxt
);
  logic stop_n, cont_n, rdwait_n, gapie_n;

  always_comb begin
    stop_n   = stop_q;
    cont_n   = cont_q;
    rdwait_n = rdwait_q;
    gapie_n  = gapie_q;
    if (wr_en) begin
      stop_n   = wr_data[CTL_STOP];
      rdwait_n = wr_data[CTL_RDWAIT];
      gapie_n  = wr_data[CTL_GAPIE];
      if (wr_data[CTL_CONT] && !wr_data[CTL_STOP]) cont_n = 1'b1;
    end
    if (done_clr) stop_n = 1'b0;
    if (restart)  cont_n = 1'b0;
  end

  assign rdwait_nxt = rdwait_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      stop_q   <= 1'b0;
      cont_q   <= 1'b0;
      rdwait_q <= 1'b0;
      gapie_q  <= 1'b0;
    end else begin
      stop_q   <= stop_n;
      cont_q   <= cont_n;
      rdwait_q <= rdwait_n;
      gapie_q  <= gapie_n;
    end
  end

  AST_CONT_GATED: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_data[CTL_STOP] && !cont_q) |=> !cont_q); // R3
  AST_DONE_CLR_STOP: assert property (@(posedge clk) disable iff (rst)
    done_clr |=> !stop_q); // R9
endmodule

// File: rtl/gap_blk_counter.sv
module gap_blk_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  output logic             last
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (dec)  cnt_q <= cnt_q - 1'b1;
  end

  assign last = (cnt_q == CNT_W'(1));

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    dec |-> (cnt_q != '0)); // R9
endmodule

// File: rtl/gap_pause_fsm.sv
module gap_pause_fsm
  import sd_gap_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xfer_start,
  input  logic xfer_is_read,
  input  logic blocks_nz,
  input  logic blk_end,
  input  logic last_blk,
  input  logic stop,
  input  logic cont,
  input  logic rdwait_nxt,
  output logic load,
  output logic dec,
  output logic restart,
  output logic done_clr,
  output logic blk_go,
  output logic rd_active,
  output logic wr_active,
  output logic dat_active,
  output logic dat_inhibit,
  output logic rdwait_req,
  output logic clk_stop_req,
  output logic xfer_done,
  output logic gap_evt
);
  gap_state_e st_q, st_n;
  logic       is_read_q, rd_n;

  always_comb begin
    st_n = st_q;
    load = 1'b0;
    dec  = 1'b0;
    case (st_q)
      ST_IDLE:  if (xfer_start && blocks_nz) begin
                  st_n = ST_XFER;
                  load = 1'b1;
                end
      ST_XFER:  if (blk_end) begin
                  dec = 1'b1;
                  if (last_blk)  st_n = ST_DONE;
                  else if (stop) st_n = ST_PAUSE;
                end
      ST_PAUSE: if (cont && !stop) st_n = ST_XFER;
      ST_DONE:  st_n = ST_IDLE;
      default:  st_n = ST_IDLE;
    endcase
  end

  assign restart  = (st_n == ST_XFER) && (st_q != ST_XFER);
  assign done_clr = (st_q == ST_XFER) && blk_end && last_blk;
  assign rd_n     = load ? xfer_is_read : is_read_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_IDLE;
      is_read_q    <= 1'b0;
      blk_go       <= 1'b0;
      rd_active    <= 1'b0;
      wr_active    <= 1'b0;
      dat_active   <= 1'b0;
      dat_inhibit  <= 1'b0;
      rdwait_req   <= 1'b0;
      clk_stop_req <= 1'b0;
      xfer_done    <= 1'b0;
      gap_evt      <= 1'b0;
    end else begin
      st_q         <= st_n;
      is_read_q    <= rd_n;
      blk_go       <= (st_n == ST_XFER);
      rd_active    <= (st_n == ST_XFER) && rd_n;
      wr_active    <= (st_n == ST_XFER) && !rd_n;
      dat_active   <= (st_n == ST_XFER);
      dat_inhibit  <= (st_n == ST_XFER);
      rdwait_req   <= (st_n == ST_PAUSE) && rd_n && rdwait_nxt;
      clk_stop_req <= (st_n == ST_PAUSE) && rd_n && !rdwait_nxt;
      xfer_done    <= (st_n == ST_DONE);
      gap_evt      <= (st_q == ST_XFER) && (st_n == ST_PAUSE);
    end
  end

  AST_PAUSE_AT_GAP: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XFER && !blk_end) |=> (st_q != ST_PAUSE)); // R4
  AST_GAP_EVT_ONE: assert property (@(posedge clk) disable iff (rst)
    gap_evt |=> !gap_evt); // R5
  AST_RESUME_GATED: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAUSE && !(cont && !stop)) |=> (st_q == ST_PAUSE)); // R6
  AST_PAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PAUSE) |-> !(blk_go || dat_active || rd_active || wr_active)); // R11
endmodule

// File: rtl/sd_gap_pause.sv
module sd_gap_pause
  import sd_gap_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr_en,
  input  logic [CTL_W-1:0] ctl_wr_data,
  output logic [CTL_W-1:0] ctl_q,
  input  logic             bus_4bit,
  input  logic             xfer_start,
  input  logic             xfer_is_read,
  input  logic [CNT_W-1:0] xfer_blocks,
  input  logic             blk_end,
  output logic             blk_go,
  output logic             rd_active,
  output logic             wr_active,
  output logic             dat_active,
  output logic             dat_inhibit,
  output logic             rdwait_req,
  output logic             clk_stop_req,
  output logic             xfer_done,
  output logic             gap_evt,
  output logic             gap_irq_en
);
  logic stop_q, cont_q, rdwait_q, gapie_q, rdwait_nxt;
  logic load, dec, restart, done_clr, last_blk;

  gap_ctl_regs u_regs (
    .clk(clk), .rst(rst), .wr_en(ctl_wr_en), .wr_data(ctl_wr_data),
    .restart(restart), .done_clr(done_clr),
    .stop_q(stop_q), .cont_q(cont_q), .rdwait_q(rdwait_q), .gapie_q(gapie_q),
    .rdwait_nxt(rdwait_nxt)
  );

  gap_blk_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(xfer_blocks),
    .dec(dec), .last(last_blk)
  );

  gap_pause_fsm u_fsm (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_is_read(xfer_is_read),
    .blocks_nz(xfer_blocks != '0), .blk_end(blk_end), .last_blk(last_blk),
    .stop(stop_q), .cont(cont_q), .rdwait_nxt(rdwait_nxt),
    .load(load), .dec(dec), .restart(restart), .done_clr(done_clr),
    .blk_go(blk_go), .rd_active(rd_active), .wr_active(wr_active),
    .dat_active(dat_active), .dat_inhibit(dat_inhibit),
    .rdwait_req(rdwait_req), .clk_stop_req(clk_stop_req),
    .xfer_done(xfer_done), .gap_evt(gap_evt)
  );

  always_comb begin
    ctl_q             = '0;
    ctl_q[CTL_STOP]   = stop_q;
    ctl_q[CTL_CONT]   = cont_q;
    ctl_q[CTL_RDWAIT] = rdwait_q;
    ctl_q[CTL_GAPIE]  = gapie_q;
  end

  assign gap_irq_en = gapie_q && bus_4bit;

  AST_CONT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    $rose(dat_active) |-> !cont_q); // R7
  AST_HOLD_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    (rdwait_req || clk_stop_req) |-> (!blk_go && !wr_active)); // R8
endmodule

// File: tb/sd_gap_pause_tb.sv
module sd_gap_pause_tb;
  localparam int CNT_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_wr_en = 1'b0;
  logic [3:0] ctl_wr_data = '0;
  logic [3:0] ctl_q;
  logic bus_4bit = 1'b0;
  logic xfer_start = 1'b0;
  logic xfer_is_read = 1'b0;
  logic [CNT_W-1:0] xfer_blocks = '0;
  logic blk_end = 1'b0;
  logic blk_go, rd_active, wr_active, dat_active, dat_inhibit;
  logic rdwait_req, clk_stop_req, xfer_done, gap_evt, gap_irq_en;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sd_gap_pause #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst(rst), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .ctl_q(ctl_q), .bus_4bit(bus_4bit), .xfer_start(xfer_start),
    .xfer_is_read(xfer_is_read), .xfer_blocks(xfer_blocks), .blk_end(blk_end),
    .blk_go(blk_go), .rd_active(rd_active), .wr_active(wr_active),
    .dat_active(dat_active), .dat_inhibit(dat_inhibit), .rdwait_req(rdwait_req),
    .clk_stop_req(clk_stop_req), .xfer_done(xfer_done), .gap_evt(gap_evt),
    .gap_irq_en(gap_irq_en)
  );

  // Behavioural model: mode 0 idle, 1 running, 2 paused, 3 finishing
  int m_mode = 0;
  int m_left = 0;
  bit m_read = 0;
  bit m_stop = 0, m_cont = 0, m_rw = 0, m_ie = 0;
  bit m_evt = 0;

  always @(posedge clk) begin
    int nm;
    bit ns, nc;
    if (rst) begin
      m_mode = 0; m_left = 0; m_read = 0;
      m_stop = 0; m_cont = 0; m_rw = 0; m_ie = 0; m_evt = 0;
    end else begin
      nm = m_mode;
      ns = m_stop;
      nc = m_cont;
      if (ctl_wr_en) begin
        ns = ctl_wr_data[0];
        if (ctl_wr_data[1] && !ctl_wr_data[0]) nc = 1;
      end
      if (m_mode == 0 && xfer_start && xfer_blocks != 0) begin
        nm = 1; m_left = xfer_blocks; m_read = xfer_is_read;
      end else if (m_mode == 1 && blk_end) begin
        m_left = m_left - 1;
        if (m_left == 0) begin nm = 3; ns = 0; end
        else if (m_stop) nm = 2;
      end else if (m_mode == 2 && m_cont && !m_stop) begin
        nm = 1;
      end else if (m_mode == 3) begin
        nm = 0;
      end
      if (nm == 1 && m_mode != 1) nc = 0;
      m_evt = (m_mode == 1 && nm == 2);
      if (ctl_wr_en) begin
        m_rw = ctl_wr_data[2];
        m_ie = ctl_wr_data[3];
      end
      m_mode = nm; m_stop = ns; m_cont = nc;
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic compare_all();
    bit run, pz;
    run = (m_mode == 1);
    pz  = (m_mode == 2);
    chk("R2 R3 R7 ctl_q", ctl_q, {m_ie, m_rw, m_cont, m_stop});
    chk("R4 R11 blk_go", {3'b0, blk_go}, {3'b0, run});
    chk("R4 R11 rd_active", {3'b0, rd_active}, {3'b0, run && m_read});
    chk("R4 R11 wr_active", {3'b0, wr_active}, {3'b0, run && !m_read});
    chk("R4 R7 dat_active", {3'b0, dat_active}, {3'b0, run});
    chk("R4 R11 dat_inhibit", {3'b0, dat_inhibit}, {3'b0, run});
    chk("R8 rdwait_req", {3'b0, rdwait_req}, {3'b0, pz && m_read && m_rw});
    chk("R8 clk_stop_req", {3'b0, clk_stop_req}, {3'b0, pz && m_read && !m_rw});
    chk("R9 xfer_done", {3'b0, xfer_done}, {3'b0, m_mode == 3});
    chk("R5 gap_evt", {3'b0, gap_evt}, {3'b0, m_evt});
    chk("R10 gap_irq_en", {3'b0, gap_irq_en}, {3'b0, m_ie && bus_4bit});
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      cycles++;
      compare_all();
    end
  endtask

  task automatic wr(input logic [3:0] d);
    ctl_wr_en = 1'b1; ctl_wr_data = d;
    tick();
    ctl_wr_en = 1'b0;
  endtask

  task automatic start(input bit rd, input int n);
    xfer_start = 1'b1; xfer_is_read = rd; xfer_blocks = CNT_W'(n);
    tick();
    xfer_start = 1'b0;
  endtask

  task automatic bend();
    blk_end = 1'b1;
    tick();
    blk_end = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1: reset state
    chk("R1 reset ctl_q", ctl_q, 4'h0);
    chk("R1 reset status", {blk_go, dat_active, xfer_done, gap_evt}, 4'h0);

    // R2, R10: field positions and gap interrupt gating
    wr(4'b1100);
    tick();
    bus_4bit = 1'b1;
    tick();
    chk("R10 irq on 4-bit", {3'b0, gap_irq_en}, 4'h1);
    wr(4'b0000);
    bus_4bit = 1'b0;
    tick();

    // Plain write, 3 blocks, no stop
    start(0, 3);
    tick(2); bend(); tick(2); bend(); tick(2); bend();
    tick(3);

    // Read with read-wait, stop mid-block
    start(1, 4);
    tick(2);
    wr(4'b0101);
    tick(3);
    chk("R4 still running mid-block", {3'b0, blk_go}, 4'h1);
    bend();
    chk("R5 gap_evt at pause", {3'b0, gap_evt}, 4'h1);
    chk("R8 rdwait during read pause", {3'b0, rdwait_req}, 4'h1);
    tick(3);
    wr(4'b0100);
    tick(3);
    chk("R6 clear-both no resume", {3'b0, blk_go}, 4'h0);
    wr(4'b0111);
    tick(2);
    chk("R3 continue ignored with stop", {3'b0, ctl_q[1]}, 4'h0);
    wr(4'b0100);
    wr(4'b0110);
    tick();
    chk("R7 resumed and continue cleared", {blk_go, ctl_q[1], 2'b0}, 4'b1000);
    tick(2); bend(); tick(); bend(); bend();
    tick(3);

    // Read with clock stop, then resume; continue written 0 has no effect
    wr(4'b0000);
    start(1, 3);
    tick();
    wr(4'b0001);
    bend();
    chk("R8 clock stop without read-wait", {3'b0, clk_stop_req}, 4'h1);
    tick(2);
    wr(4'b0010);
    tick(2);
    bend(); tick(); bend();
    tick(3);

    // Paused write: no hold requests
    start(0, 3);
    tick();
    wr(4'b0101);
    bend();
    chk("R8 write pause no hold", {2'b0, rdwait_req, clk_stop_req}, 4'h0);
    tick(2);
    wr(4'b0110);
    tick(2);
    bend(); bend();
    tick(3);

    // Stop pending on the last block: complete, no pause
    wr(4'b0001);
    start(0, 1);
    tick(2);
    bend();
    chk("R9 done not pause", {2'b0, xfer_done, gap_evt}, 4'b0010);
    chk("R9 stop cleared", {3'b0, ctl_q[0]}, 4'h0);
    tick(3);

    // Continue set while idle clears when a transfer starts
    wr(4'b0010);
    tick();
    start(1, 2);
    chk("R7 continue cleared at start", {3'b0, ctl_q[1]}, 4'h0);
    bend(); bend();
    tick(3);

    summary();
  end
endmodule